// File: doc/BRIEF.md
# Interrupt CPU interface with split completion

This block is the per-processor end of an interrupt controller. A source upstream pulses a pending request for each interrupt line and supplies an 8-bit priority for every line. The block picks the most urgent line that is pending and not already in service. It compares that line's priority against a software mask and against the priority of the handler that is running now. When the line wins, the block raises `irq` toward the processor. Software talks to the block through a small register port that decodes an 8 KB window.

Software reads the acknowledge register to take the winning interrupt. That read moves the line from pending to active and pushes its priority onto a running-priority stack. Completion has two forms. In combined mode, one end-of-interrupt write drops the running priority and retires the line. In split mode, the end-of-interrupt write only releases the priority, and the line stays active. A later write to the deactivate register retires it. This lets one agent drop priority early and hand final deactivation to another agent.

Top module: `irq_cpu_port`

## Requirements
- R1: After reset, `irq` is low, the control register and the mask register read as 0, and an acknowledge read returns 1023.
- R2: The control register sits at offset 0x000. Bit 0 enables signalling and bit 9 selects split completion, and both read back. The mask register sits at offset 0x004 and keeps wdata[7:0]. `irq` is never high while bit 0 is clear.
- R3: The candidate is the pending, non-active line with the numerically lowest priority, and a tie goes to the lower ID. It is signalled only when its priority is strictly below the mask and strictly below the running priority. The running priority is 0x100 when the stack is empty.
- R4: A read of offset 0x00C while a candidate is signalled returns its ID in bits [9:0] and zero above. The read clears the line's pending state, sets its active state and pushes its priority as the new running priority.
- R5: An acknowledge read with no signalled candidate returns 1023 and changes no state. This covers reads made while signalling is disabled.
- R6: In combined mode (bit 9 clear), a write of an ID to offset 0x010 pops the running priority and clears that line's active state.
- R7: In split mode (bit 9 set), the same write only pops the running priority. The line stays active, so an equal-priority line can then be taken. The still-active line is not signalled again, even after it is pended again.
- R8: A write of an ID to offset 0x1000 clears that line's active state in either mode. A write that names a line which is not active changes nothing.
- R9: Each end-of-interrupt pops the most recently pushed priority, so nested handlers unwind in reverse acknowledge order.
- R10: While the stack holds STACK_DEPTH entries, nothing is signalled and an acknowledge read returns 1023. An end-of-interrupt write with an empty stack is ignored, and in combined mode it then leaves the named line active.
- R11: Register reads return data one cycle later with `rvalid`. Unmapped offsets read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_set | input | NUM_IRQ | One-cycle pulse per line that marks it pending |
| irq_prio | input | NUM_IRQ*8 | Priority of each line, line i in bits [8i+7:8i] |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 13 | Byte offset in the 8 KB window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The hardest state to reach from the ports is a line that is active but no longer holds a stack entry. Only split mode creates it, and it then has to sit next to a re-pended copy of the same line and next to an equal-priority neighbour. The bench builds this state with a split end-of-interrupt, then pends the line again. It checks that the neighbour is taken and the line is not. It then switches to combined mode while the stack is empty, so that a stray end-of-interrupt must leave the line active. Around these cases, the bench sweeps every line on its own and drains all 32 lines at once against a priority table computed with many ties, predicting each acknowledge in arithmetic.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned PRIO_W = 8;
  localparam int unsigned ID_W   = 10;
  localparam int unsigned ADDR_W = 13;
  localparam int unsigned DATA_W = 32;

  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  localparam logic [ADDR_W-1:0] OFF_CTRL  = 13'h0000;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 13'h0004;
  localparam logic [ADDR_W-1:0] OFF_ACK   = 13'h000C;
  localparam logic [ADDR_W-1:0] OFF_EOI   = 13'h0010;
  localparam logic [ADDR_W-1:0] OFF_DEACT = 13'h1000;

  localparam int unsigned CTRL_EN_BIT    = 0;
  localparam int unsigned CTRL_SPLIT_BIT = 9;

  // Running priority when no handler is in service: above every 8-bit value.
  localparam logic [PRIO_W:0] RUN_IDLE = 9'h100;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_MASK,
    SEL_ACK,
    SEL_EOI,
    SEL_DEACT
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    case (a)
      OFF_CTRL:  s = SEL_CTRL;
      OFF_MASK:  s = SEL_MASK;
      OFF_ACK:   s = SEL_ACK;
      OFF_EOI:   s = SEL_EOI;
      OFF_DEACT: s = SEL_DEACT;
      default:   s = SEL_NONE;
    endcase
    return s;
  endfunction

  // A candidate is forwarded only when strictly more urgent than both limits.
  function automatic logic prio_beats(input logic [PRIO_W-1:0] cand,
                                      input logic [PRIO_W-1:0] mask,
                                      input logic [PRIO_W:0]   running);
    return (cand < mask) && ({1'b0, cand} < running);
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_word(input logic en, input logic split);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CTRL_EN_BIT]    = en;
    w[CTRL_SPLIT_BIT] = split;
    return w;
  endfunction

endpackage

// File: rtl/irqc_state_bank.sv
module irqc_state_bank
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] pend_set,
  input  logic               take,
  input  logic [IDX_W-1:0]   take_idx,
  input  logic               retire,
  input  logic [ID_W-1:0]    retire_id,
  output logic [NUM_IRQ-1:0] pending,
  output logic [NUM_IRQ-1:0] active
);

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    logic take_hit;
    logic retire_hit;

    assign take_hit   = take && (take_idx == IDX_W'(g));
    assign retire_hit = retire && (retire_id == ID_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pending[g] <= 1'b0;
      end else if (pend_set[g]) begin
        pending[g] <= 1'b1;
      end else if (take_hit) begin
        pending[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        active[g] <= 1'b0;
      end else if (take_hit) begin
        active[g] <= 1'b1;
      end else if (retire_hit) begin
        active[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0]        pending,
  input  logic [NUM_IRQ-1:0]        active,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
  output logic                      win_valid,
  output logic [IDX_W-1:0]          win_idx,
  output logic [PRIO_W-1:0]         win_prio
);

  logic [NUM_IRQ-1:0] eligible;

  assign eligible = pending & ~active;

  // Ascending scan with strict compare keeps the lower ID on a tie.
  always_comb begin
    logic [PRIO_W-1:0] p;
    win_valid = 1'b0;
    win_idx   = '0;
    win_prio  = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      p = prio_flat[i*PRIO_W +: PRIO_W];
      if (eligible[i] && (!win_valid || (p < win_prio))) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_prio  = p;
      end
    end
  end

endmodule

// File: rtl/irqc_prio_stack.sv
module irqc_prio_stack
  import irqc_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic              pop,
  output logic [PRIO_W:0]   top,
  output logic              full,
  output logic              empty
);

  logic [PRIO_W-1:0] slot [DEPTH];
  logic [CNT_W-1:0]  count;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (push && !full) begin
      count <= count + CNT_W'(1);
    end else if (pop && !empty) begin
      count <= count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) slot[k] <= '0;
    end else if (push && !full) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (count == CNT_W'(k)) slot[k] <= push_prio;
      end
    end
  end

  always_comb begin
    top = RUN_IDLE;
    for (int k = 0; k < DEPTH; k++) begin
      if (count == CNT_W'(k + 1)) top = {1'b0, slot[k]};
    end
  end

endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_IRQ     = 32,
  parameter int unsigned STACK_DEPTH = 4,
  localparam int unsigned IDX_W      = $clog2(NUM_IRQ)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        pend_set,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rdata,
  output logic                      rvalid,
  output logic                      irq
);

  reg_sel_e sel;
  logic ctrl_en, split_mode;
  logic [PRIO_W-1:0] mask_q;

  // Named internal events, also used by the bound checker.
  logic ack_rd, ack_ok, eoi_wr, eoi_pop, deact_wr, retire, qualify;
  logic [ID_W-1:0] wr_id;

  logic [NUM_IRQ-1:0] pending_vec, active_vec;
  logic win_valid;
  logic [IDX_W-1:0] win_idx;
  logic [PRIO_W-1:0] win_prio;
  logic [PRIO_W:0] run_prio;
  logic stack_full, stack_empty;
  logic unused_wdata_hi;

  assign sel             = decode_offset(addr);
  assign wr_id           = wdata[ID_W-1:0];
  assign unused_wdata_hi = ^wdata[DATA_W-1:ID_W];

  assign qualify  = ctrl_en && win_valid && !stack_full && prio_beats(win_prio, mask_q, run_prio);
  assign irq      = qualify;
  assign ack_rd   = rd_en && (sel == SEL_ACK);
  assign ack_ok   = ack_rd && qualify;
  assign eoi_wr   = wr_en && (sel == SEL_EOI);
  assign eoi_pop  = eoi_wr && !stack_empty;
  assign deact_wr = wr_en && (sel == SEL_DEACT);
  assign retire   = deact_wr || (eoi_pop && !split_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en    <= 1'b0;
      split_mode <= 1'b0;
      mask_q     <= '0;
    end else if (wr_en) begin
      if (sel == SEL_CTRL) begin
        ctrl_en    <= wdata[CTRL_EN_BIT];
        split_mode <= wdata[CTRL_SPLIT_BIT];
      end
      if (sel == SEL_MASK) mask_q <= wdata[PRIO_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) begin
        case (sel)
          SEL_CTRL: rdata <= ctrl_word(ctrl_en, split_mode);
          SEL_MASK: rdata <= DATA_W'(mask_q);
          SEL_ACK:  rdata <= ack_ok ? DATA_W'(win_idx) : DATA_W'(SPURIOUS_ID);
          default:  rdata <= '0;
        endcase
      end
    end
  end

  irqc_state_bank #(.NUM_IRQ(NUM_IRQ)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_set  (pend_set),
    .take      (ack_ok),
    .take_idx  (win_idx),
    .retire    (retire),
    .retire_id (wr_id),
    .pending   (pending_vec),
    .active    (active_vec)
  );

  irqc_arbiter #(.NUM_IRQ(NUM_IRQ)) u_arb (
    .pending   (pending_vec),
    .active    (active_vec),
    .prio_flat (irq_prio),
    .win_valid (win_valid),
    .win_idx   (win_idx),
    .win_prio  (win_prio)
  );

  irqc_prio_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ack_ok),
    .push_prio (win_prio),
    .pop       (eoi_pop),
    .top       (run_prio),
    .full      (stack_full),
    .empty     (stack_empty)
  );

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_IRQ)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_en,
  input logic               wr_en,
  input logic [ID_W-1:0]    wr_id,
  input logic [DATA_W-1:0]  rdata,
  input logic               irq,
  input logic               ctrl_en,
  input logic               split_mode,
  input logic               ack_rd,
  input logic               ack_ok,
  input logic               eoi_pop,
  input logic               stack_full,
  input logic [PRIO_W:0]    run_prio,
  input logic [PRIO_W-1:0]  win_prio,
  input logic [NUM_IRQ-1:0] active_vec
);

  logic [NUM_IRQ-1:0] eoi_mask;

  always_comb begin
    eoi_mask = '0;
    if (wr_id < ID_W'(NUM_IRQ)) eoi_mask[wr_id[IDX_W-1:0]] = 1'b1;
  end

  p_irq_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl_en);

  p_ack_pushes_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_ok |=> (run_prio == {1'b0, $past(win_prio)}));

  p_spurious_no_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !ack_ok && !wr_en) |=>
      ((rdata == DATA_W'(SPURIOUS_ID)) && (active_vec == $past(active_vec))
       && (run_prio == $past(run_prio))));

  p_combined_retires_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_pop && !split_mode) |=> ((active_vec & $past(eoi_mask)) == '0));

  p_split_keeps_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_pop && split_mode && !rd_en) |=> (active_vec == $past(active_vec)));

  p_one_line_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(active_vec ^ $past(active_vec)));

  p_full_blocks_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && stack_full) |=> (rdata == DATA_W'(SPURIOUS_ID)));

endmodule

bind irq_cpu_port irqc_checker #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_en      (rd_en),
  .wr_en      (wr_en),
  .wr_id      (wr_id),
  .rdata      (rdata),
  .irq        (irq),
  .ctrl_en    (ctrl_en),
  .split_mode (split_mode),
  .ack_rd     (ack_rd),
  .ack_ok     (ack_ok),
  .eoi_pop    (eoi_pop),
  .stack_full (stack_full),
  .run_prio   (run_prio),
  .win_prio   (win_prio),
  .active_vec (active_vec)
);

// File: tb/irq_cpu_port_test.sv
module irq_cpu_port_test;

  localparam int N = 32;
  localparam logic [12:0] A_CTRL = 13'h0000, A_MASK = 13'h0004, A_ACK = 13'h000C,
                          A_EOI = 13'h0010, A_DEACT = 13'h1000;
  localparam logic [31:0] SPUR = 32'd1023, MODE_COMB = 32'h1, MODE_SPLIT = 32'h201;

  logic clk = 1'b0;
  logic rst_n, wr_en, rd_en, rvalid, irq;
  logic [12:0] addr;
  logic [31:0] wdata, rdata;
  logic [N-1:0] pend_set;
  logic [7:0] prio_b [N];
  logic [N*8-1:0] irq_prio;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) irq_prio[i*8 +: 8] = prio_b[i];
  end

  irq_cpu_port #(.NUM_IRQ(N), .STACK_DEPTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .pend_set(pend_set), .irq_prio(irq_prio),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pend(input int id);
    @(negedge clk); pend_set[id] = 1'b1;
    @(negedge clk); pend_set = '0;
  endtask

  task automatic ack_expect(input string tag, input logic [31:0] exp);
    logic [31:0] d;
    rd(A_ACK, d);
    chk(tag, d, exp);
  endtask

  function automatic int pick(input logic [N-1:0] pm);
    int best = -1;
    for (int i = 0; i < N; i++)
      if (pm[i] && (best < 0 || prio_b[i] < prio_b[best])) best = i;
    return best;
  endfunction

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [N-1:0] model;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; pend_set = '0;
    for (int i = 0; i < N; i++) prio_b[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
    rd(A_MASK, d); chk("R1 mask", d, 32'h0);
    ack_expect("R1 ack", SPUR);

    // R2 control and mask registers, R11 read latency
    @(negedge clk); addr = A_CTRL; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    chk("R11 rvalid", {31'b0, rvalid}, 32'h1);
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, d); chk("R2 ctrl bits", d, 32'h201);
    wr(A_MASK, 32'h1AB);       rd(A_MASK, d); chk("R2 mask", d, 32'hAB);
    wr(A_MASK, 32'hF0);
    wr(A_CTRL, MODE_COMB);

    // R3 R4 R6 single-line sweep with re-pend while active
    for (int id = 0; id < N; id++) begin
      prio_b[id] = 8'((id * 7) % 240);
      pend(id);
      chk($sformatf("R3 irq line %0d", id), {31'b0, irq}, 32'h1);
      ack_expect($sformatf("R4 ack line %0d", id), 32'(id));
      chk("R4 irq after ack", {31'b0, irq}, 32'h0);
      ack_expect("R5 second ack", SPUR);
      pend(id);
      chk("R6 active not resignalled", {31'b0, irq}, 32'h0);
      wr(A_EOI, 32'(id));
      chk("R6 retired line pending again", {31'b0, irq}, 32'h1);
      ack_expect("R6 retake", 32'(id));
      wr(A_EOI, 32'(id));
      chk("R6 idle", {31'b0, irq}, 32'h0);
    end

    // R3 mask boundary
    prio_b[3] = 8'h80;
    wr(A_MASK, 32'h80); pend(3);
    chk("R3 equal to mask", {31'b0, irq}, 32'h0);
    ack_expect("R3 masked ack", SPUR);
    wr(A_MASK, 32'h81);
    chk("R3 below mask", {31'b0, irq}, 32'h1);
    ack_expect("R3 unmasked ack", 32'd3);
    wr(A_EOI, 32'd3);
    wr(A_MASK, 32'hF0);

    // R5 disabled signalling
    wr(A_CTRL, 32'h0); pend(4);
    chk("R5 disabled irq", {31'b0, irq}, 32'h0);
    ack_expect("R5 disabled ack", SPUR);
    wr(A_CTRL, MODE_COMB);
    chk("R2 enabled irq", {31'b0, irq}, 32'h1);
    ack_expect("R5 ack after enable", 32'd4);
    wr(A_EOI, 32'd4);

    // R3 all lines pending, ties in priority, drained in predicted order
    for (int i = 0; i < N; i++) prio_b[i] = 8'((i * 53) + 17) & 8'hE0;
    for (int i = 0; i < N; i++) pend(i);
    model = '1;
    for (int k = 0; k < N; k++) begin
      int e;
      e = pick(model);
      ack_expect($sformatf("R3 drain step %0d", k), 32'(e));
      wr(A_EOI, 32'(e));
      model[e] = 1'b0;
    end
    ack_expect("R3 drained", SPUR);

    // R9 nesting
    prio_b[8] = 8'h80; prio_b[9] = 8'h40; prio_b[10] = 8'h60; prio_b[11] = 8'h90;
    pend(8); ack_expect("R9 outer", 32'd8);
    pend(11); chk("R3 below running", {31'b0, irq}, 32'h0);
    pend(9); chk("R9 preempt irq", {31'b0, irq}, 32'h1);
    ack_expect("R9 inner", 32'd9);
    pend(10); chk("R9 blocked by inner", {31'b0, irq}, 32'h0);
    wr(A_EOI, 32'd9);
    chk("R9 pop to outer", {31'b0, irq}, 32'h1);
    ack_expect("R9 middle", 32'd10);
    wr(A_EOI, 32'd10);
    chk("R9 back at outer", {31'b0, irq}, 32'h0);
    wr(A_EOI, 32'd8);
    chk("R9 idle", {31'b0, irq}, 32'h1);
    ack_expect("R9 last", 32'd11);
    wr(A_EOI, 32'd11);

    // R7 R8 split completion
    wr(A_CTRL, MODE_SPLIT);
    prio_b[20] = 8'h50; prio_b[21] = 8'h50; prio_b[25] = 8'h70;
    pend(20); pend(21);
    ack_expect("R3 tie lower id", 32'd20);
    chk("R7 equal prio held", {31'b0, irq}, 32'h0);
    wr(A_EOI, 32'd20);
    chk("R7 drop lets peer", {31'b0, irq}, 32'h1);
    ack_expect("R7 peer", 32'd21);
    wr(A_EOI, 32'd21);
    pend(20);
    chk("R7 active not signalled", {31'b0, irq}, 32'h0);
    ack_expect("R7 active not taken", SPUR);
    wr(A_DEACT, 32'd25);
    pend(25);
    chk("R8 inactive deact ignored irq", {31'b0, irq}, 32'h1);
    ack_expect("R8 inactive deact ignored", 32'd25);
    wr(A_EOI, 32'd25); wr(A_DEACT, 32'd25);
    wr(A_DEACT, 32'd20);
    chk("R8 deact frees", {31'b0, irq}, 32'h1);
    ack_expect("R8 retaken", 32'd20);
    wr(A_EOI, 32'd20); wr(A_DEACT, 32'd20); wr(A_DEACT, 32'd21);
    ack_expect("R8 all idle", SPUR);

    // R10 full stack
    wr(A_CTRL, MODE_COMB);
    prio_b[12] = 8'hA0; prio_b[13] = 8'h90; prio_b[14] = 8'h80;
    prio_b[15] = 8'h70; prio_b[16] = 8'h60;
    for (int i = 12; i < 16; i++) begin
      pend(i);
      ack_expect("R10 fill", 32'(i));
    end
    pend(16);
    chk("R10 full irq", {31'b0, irq}, 32'h0);
    ack_expect("R10 full ack", SPUR);
    wr(A_EOI, 32'd15);
    ack_expect("R10 after pop", 32'd16);
    wr(A_EOI, 32'd16); wr(A_EOI, 32'd14); wr(A_EOI, 32'd13); wr(A_EOI, 32'd12);

    // R10 end-of-interrupt on an empty stack
    wr(A_CTRL, MODE_SPLIT);
    pend(12); ack_expect("R10 split take", 32'd12);
    wr(A_EOI, 32'd12);
    wr(A_CTRL, MODE_COMB);
    wr(A_EOI, 32'd12);
    pend(12);
    chk("R10 empty eoi ignored", {31'b0, irq}, 32'h0);
    wr(A_DEACT, 32'd12);
    chk("R8 deact in combined", {31'b0, irq}, 32'h1);
    ack_expect("R8 retake 12", 32'd12);
    wr(A_EOI, 32'd12);

    // R11 decode
    wr(13'h0014, MODE_SPLIT); rd(A_CTRL, d); chk("R11 unmapped write", d, 32'h1);
    wr(13'h1004, 32'h10);     rd(A_MASK, d); chk("R11 alias write", d, 32'hF0);
    rd(13'h0008, d); chk("R11 unmapped read", d, 32'h0);
    rd(A_DEACT, d);  chk("R11 deact read", d, 32'h0);
    rd(A_EOI, d);    chk("R11 eoi read", d, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule